// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single-word write requests into the pin sequence an asynchronous static RAM needs for a write in which write-enable is the strobe that ends the cycle. A request is presented on a valid/ready pair. Once accepted, the block selects the chip and presents the address. It then drives the data bus and pulses write-enable low. It holds everything for a short tail and releases the chip. Before it accepts the next request it waits out the remainder of the minimum write-cycle time.

Each pin edge is placed by a cycle count. The counts are computed at elaboration from a speed-grade parameter (12, 15, 20 or 25 ns) and a clock-period parameter given in picoseconds. Every nanosecond minimum is rounded up to whole cycles, so any nonzero minimum takes at least one cycle. The pulse length is the larger of the pulse-width and data-setup counts. The setup phase is stretched when the address-to-end or select-to-end minimum is not already covered by the pulse. The data bus leaves the block as a value plus an enable; the pad tristate sits at chip level. Output-enable is kept high throughout, so the memory never drives the shared bus.

The controller has five states. IDLE is the only state in which ready is high. IDLE moves to SETUP on an accepted request. SETUP (select low, address driven) moves to PULSE when its count ends. PULSE (write-enable low, data driven) moves to HOLD after the pulse count. HOLD (write-enable high, select, address and data kept) moves to RECOVER when a cycle-time remainder exists, and otherwise back to IDLE. RECOVER (all strobes released) returns to IDLE when its count ends.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While the active-low synchronous reset is low, and on the first edge at which it is seen low even in the middle of a write, chip-select, write-enable and output-enable go high, the data enable goes low, and ready is low.
- R2: Ready is high only in IDLE. An accepted request (valid and ready both high at an edge) drops ready on that edge. Ready then stays low for max(WC, S+P+H) cycles, where S, P and H are the setup, pulse and hold counts and WC is the cycle-time count.
- R3: Chip-select falls on the edge that accepts a request, with the requested address on the address pins. The address stays unchanged while chip-select is low.
- R4: Write-enable is low only while chip-select is low, and every pulse lasts exactly P = max(ceil(pulse width), ceil(data setup)) cycles.
- R5: The data enable rises on the same edge on which write-enable falls. The data value does not change while it is enabled, and it is driven for at least the data-setup count before write-enable rises.
- R6: When write-enable rises, chip-select has been low for at least the select-to-end count, and the address has been stable for at least the address-to-end count.
- R7: For H = max(1, address-hold count, data-hold count) cycles after write-enable rises, chip-select stays low with address and data kept. Chip-select then rises on the same edge on which the data enable falls.
- R8: Output-enable is high at all times.
- R9: The word held on the data pins at the rising write-enable edge is the requested word at the requested address.
- R10: Successive falling edges of chip-select are at least WC cycles apart, for any spacing of requests.
- R11: Counts use ceil(t_ps / clock_ps), which gives at least one cycle for any nonzero minimum. Chip-select is low for exactly S = max(1, address-setup count, address-to-end count minus P, select-to-end count minus P) cycles before write-enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; period given by CLK_PS |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | DATA_W | Word to be written |
| sram_ce_n | output | 1 | Memory chip-select, active low |
| sram_we_n | output | 1 | Memory write-enable, active low |
| sram_oe_n | output | 1 | Memory output-enable, active low (kept high) |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_wdata | output | DATA_W | Value for the memory data pins |
| sram_wdata_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench builds the controller for the 25 ns grade with a 4 ns clock. This gives a four-cycle pulse set by the pulse-width minimum, a select-to-end minimum met by a single setup cycle, and a cycle-time count of seven, one more than setup, pulse and hold together. That extra cycle brings the RECOVER state and the back-to-back spacing limit within reach. The address bus is narrowed to six bits, so the bench memory model covers every location and random traffic revisits addresses. A reset asserted in the middle of a pulse exercises the abort path.

// File: rtl/sram_wr_pkg.sv
`timescale 1ns/1ps
package sram_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOVER
    } wr_state_e;

    // Write-cycle minimums of one speed grade, in picoseconds
    typedef struct packed {
        int unsigned cycle_ps;
        int unsigned sel_end_ps;
        int unsigned addr_end_ps;
        int unsigned pulse_ps;
        int unsigned dsetup_ps;
        int unsigned asetup_ps;
        int unsigned ahold_ps;
        int unsigned dhold_ps;
    } wr_timing_t;

    function automatic wr_timing_t grade_timing(input int unsigned grade_ns);
        wr_timing_t t;
        t.asetup_ps = 0;
        t.ahold_ps  = 0;
        t.dhold_ps  = 0;
        case (grade_ns)
            15: begin
                t.cycle_ps = 15000; t.sel_end_ps = 10000; t.addr_end_ps = 10000;
                t.pulse_ps = 10000; t.dsetup_ps  = 8000;
            end
            20: begin
                t.cycle_ps = 20000; t.sel_end_ps = 13000; t.addr_end_ps = 15000;
                t.pulse_ps = 13000; t.dsetup_ps  = 10000;
            end
            25: begin
                t.cycle_ps = 25000; t.sel_end_ps = 15000; t.addr_end_ps = 20000;
                t.pulse_ps = 15000; t.dsetup_ps  = 12000;
            end
            default: begin
                t.cycle_ps = 12000; t.sel_end_ps = 8000; t.addr_end_ps = 8000;
                t.pulse_ps = 8000;  t.dsetup_ps  = 6000;
            end
        endcase
        return t;
    endfunction

    // Round up to whole clock cycles; any nonzero time gives at least one
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned usub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_wr_seq.sv
`timescale 1ns/1ps
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int unsigned S_CYC   = 1,
    parameter int unsigned P_CYC   = 1,
    parameter int unsigned H_CYC   = 1,
    parameter int unsigned REC_CYC = 0,
    parameter int unsigned CNT_W   = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    output logic      req_ready,
    output logic      accept,
    output wr_state_e state_d
);

    localparam bit HAS_REC = (REC_CYC > 0);

    wr_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             cnt_done;

    assign req_ready = rst_n && (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cnt_done  = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_SETUP;
                    cnt_d   = CNT_W'(S_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (cnt_done) begin
                    state_d = ST_PULSE;
                    cnt_d   = CNT_W'(P_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_PULSE: begin
                if (cnt_done) begin
                    state_d = ST_HOLD;
                    cnt_d   = CNT_W'(H_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_done) begin
                    if (HAS_REC) begin
                        state_d = ST_RECOVER;
                        cnt_d   = CNT_W'(REC_CYC - 1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RECOVER: begin
                if (cnt_done) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sram_wr_pins.sv
`timescale 1ns/1ps
module sram_wr_pins
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_state_e         state_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_wdata_oe
);

    logic ce_n_d;
    logic we_n_d;
    logic doe_d;

    // Pin levels for the state being entered, registered below so the
    // memory strobes come straight from flops
    always_comb begin
        ce_n_d = 1'b1;
        we_n_d = 1'b1;
        doe_d  = 1'b0;
        unique case (state_d)
            ST_IDLE:    ;
            ST_SETUP:   ce_n_d = 1'b0;
            ST_PULSE: begin
                ce_n_d = 1'b0;
                we_n_d = 1'b0;
                doe_d  = 1'b1;
            end
            ST_HOLD: begin
                ce_n_d = 1'b0;
                doe_d  = 1'b1;
            end
            ST_RECOVER: ;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_ce_n     <= 1'b1;
            sram_we_n     <= 1'b1;
            sram_oe_n     <= 1'b1;
            sram_wdata_oe <= 1'b0;
            sram_addr     <= '0;
            sram_wdata    <= '0;
        end else begin
            sram_ce_n     <= ce_n_d;
            sram_we_n     <= we_n_d;
            sram_oe_n     <= 1'b1;
            sram_wdata_oe <= doe_d;
            if (accept) begin
                sram_addr  <= req_addr;
                sram_wdata <= req_data;
            end
        end
    end

endmodule

// File: rtl/sram_wr_ctrl.sv
`timescale 1ns/1ps
module sram_wr_ctrl
    import sram_wr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 15,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned GRADE_NS = 12,
    parameter int unsigned CLK_PS   = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    output logic              sram_wdata_oe
);

    localparam wr_timing_t TIM = grade_timing(GRADE_NS);

    localparam int unsigned C_WC  = ps_to_cycles(TIM.cycle_ps,    CLK_PS);
    localparam int unsigned C_SCE = ps_to_cycles(TIM.sel_end_ps,  CLK_PS);
    localparam int unsigned C_AW  = ps_to_cycles(TIM.addr_end_ps, CLK_PS);
    localparam int unsigned C_PWE = ps_to_cycles(TIM.pulse_ps,    CLK_PS);
    localparam int unsigned C_SD  = ps_to_cycles(TIM.dsetup_ps,   CLK_PS);
    localparam int unsigned C_SA  = ps_to_cycles(TIM.asetup_ps,   CLK_PS);
    localparam int unsigned C_HA  = ps_to_cycles(TIM.ahold_ps,    CLK_PS);
    localparam int unsigned C_HD  = ps_to_cycles(TIM.dhold_ps,    CLK_PS);

    localparam int unsigned P_CYC   = umax(C_PWE, C_SD);
    localparam int unsigned S_CYC   = umax(1, umax(C_SA,
                                          umax(usub(C_AW, P_CYC), usub(C_SCE, P_CYC))));
    localparam int unsigned H_CYC   = umax(1, umax(C_HA, C_HD));
    localparam int unsigned REC_CYC = usub(C_WC, S_CYC + P_CYC + H_CYC);
    localparam int unsigned MAX_CYC = umax(umax(S_CYC, P_CYC), umax(H_CYC, REC_CYC));
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 2);

    wr_state_e state_d;
    logic      accept;

    sram_wr_seq #(
        .S_CYC   (S_CYC),
        .P_CYC   (P_CYC),
        .H_CYC   (H_CYC),
        .REC_CYC (REC_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .state_d   (state_d)
    );

    sram_wr_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_d       (state_d),
        .accept        (accept),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .sram_ce_n     (sram_ce_n),
        .sram_we_n     (sram_we_n),
        .sram_oe_n     (sram_oe_n),
        .sram_addr     (sram_addr),
        .sram_wdata    (sram_wdata),
        .sram_wdata_oe (sram_wdata_oe)
    );

endmodule

// File: rtl/sram_wr_ctrl_chk.sv
`timescale 1ns/1ps
module sram_wr_ctrl_chk #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned P_CYC  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_wdata,
    input logic              sram_wdata_oe
);

    logic [15:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || sram_we_n) begin
            we_low_cnt <= '0;
        end else begin
            we_low_cnt <= we_low_cnt + 16'd1;
        end
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !sram_ce_n));

    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_ce_n);

    a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt == 16'(P_CYC)));

    a_r5_data_with_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $rose(sram_wdata_oe));

    a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_wdata_oe && $past(sram_wdata_oe)) |-> $stable(sram_wdata));

    a_r7_hold_tail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (!sram_ce_n && sram_wdata_oe && $stable(sram_addr)));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_ce_n) |-> (!sram_wdata_oe && sram_we_n));

endmodule

bind sram_wr_ctrl sram_wr_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .P_CYC  (P_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .sram_ce_n     (sram_ce_n),
    .sram_we_n     (sram_we_n),
    .sram_addr     (sram_addr),
    .sram_wdata    (sram_wdata),
    .sram_wdata_oe (sram_wdata_oe)
);

// File: tb/sram_wr_ctrl_bench.sv
`timescale 1ns/1ps
module sram_wr_ctrl_bench;

    localparam int CLK_PS  = 4000;
    localparam int HALF_NS = CLK_PS / 2000;
    localparam int GRADE   = 25;
    localparam int AW      = 6;
    localparam int DW      = 8;
    localparam int DEPTH   = 1 << AW;

    function automatic int cyc_of(input int t_ns);
        return (t_ns * 1000 + CLK_PS - 1) / CLK_PS;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // 25 ns grade minimums, converted by the rule of R11
    localparam int E_WC   = cyc_of(25);
    localparam int E_SCE  = cyc_of(15);
    localparam int E_AW   = cyc_of(20);
    localparam int E_PWE  = cyc_of(15);
    localparam int E_SD   = cyc_of(12);
    localparam int E_P    = imax(E_PWE, E_SD);
    localparam int E_S    = imax(1, imax(E_AW - E_P, E_SCE - E_P));
    localparam int E_H    = 1;
    localparam int E_BUSY = imax(E_WC, E_S + E_P + E_H);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          sram_ce_n;
    logic          sram_we_n;
    logic          sram_oe_n;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_wdata;
    logic          sram_wdata_oe;

    int checks = 0;
    int fails  = 0;

    always #(HALF_NS) clk = ~clk;

    sram_wr_ctrl #(
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .GRADE_NS (GRADE),
        .CLK_PS   (CLK_PS)
    ) u_sram_wr_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .sram_ce_n     (sram_ce_n),
        .sram_we_n     (sram_we_n),
        .sram_oe_n     (sram_oe_n),
        .sram_addr     (sram_addr),
        .sram_wdata    (sram_wdata),
        .sram_wdata_oe (sram_wdata_oe)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Memory stub: samples the pins at the falling clock edge
    logic [DW-1:0] mem   [DEPTH];
    logic [DW-1:0] model [DEPTH];
    bit            wrote [DEPTH];
    int            ce_cnt, we_cnt, doe_cnt, addr_cnt, cyc, last_fall;
    bit            seen_fall;
    logic          prev_we, prev_ce;
    logic [AW-1:0] prev_addr;

    always @(negedge clk) begin
        if (!rst_n) begin
            ce_cnt = 0; we_cnt = 0; doe_cnt = 0; addr_cnt = 0;
            cyc = 0; last_fall = 0; seen_fall = 0;
            prev_we = 1'b1; prev_ce = 1'b1; prev_addr = sram_addr;
        end else begin
            if (prev_ce && !sram_ce_n) begin
                if (seen_fall)
                    chk(cyc - last_fall >= E_WC, "R10 select-fall spacing", cyc - last_fall, E_WC);
                last_fall = cyc;
                seen_fall = 1;
            end
            if (prev_we && !sram_we_n) begin
                chk(ce_cnt == E_S, "R11 setup cycles", ce_cnt, E_S);
                chk(sram_wdata_oe, "R5 data enable at pulse start", sram_wdata_oe, 1);
            end
            if (!prev_we && sram_we_n) begin
                chk(we_cnt == E_P, "R4 pulse length", we_cnt, E_P);
                chk(ce_cnt >= E_SCE, "R6 select to end", ce_cnt, E_SCE);
                chk(addr_cnt >= E_AW, "R6 address to end", addr_cnt, E_AW);
                chk(doe_cnt >= E_SD, "R5 data setup", doe_cnt, E_SD);
                chk(!sram_ce_n && sram_wdata_oe && sram_addr == prev_addr,
                    "R7 hold tail", {sram_ce_n, sram_wdata_oe}, 2'b01);
                chk(sram_oe_n, "R8 output-enable high", sram_oe_n, 1);
                mem[sram_addr] = sram_wdata;
            end
            if (!prev_ce && sram_ce_n)
                chk(!sram_wdata_oe && sram_we_n, "R7 release",
                    {sram_wdata_oe, sram_we_n}, 2'b01);
            if (!sram_we_n && sram_ce_n)
                chk(0, "R4 write-enable outside select", sram_ce_n, 0);
            ce_cnt   = sram_ce_n ? 0 : ce_cnt + 1;
            we_cnt   = sram_we_n ? 0 : we_cnt + 1;
            doe_cnt  = sram_wdata_oe ? doe_cnt + 1 : 0;
            addr_cnt = sram_ce_n ? 0 : ((sram_addr == prev_addr && ce_cnt > 1) ? addr_cnt + 1 : 1);
            prev_we   = sram_we_n;
            prev_ce   = sram_ce_n;
            prev_addr = sram_addr;
            cyc++;
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
        int lowc;
        repeat (gap) @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready drops on accept", req_ready, 0);
        chk(!sram_ce_n && sram_addr == a, "R3 select with address", sram_addr, a);
        lowc = 0;
        while (!req_ready) begin
            lowc++;
            @(negedge clk);
        end
        chk(lowc == E_BUSY, "R2 busy length", lowc, E_BUSY);
        model[a] = d;
        wrote[a] = 1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(0, "R2 watchdog expired", 50000, 0);
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_wdata_oe && !req_ready,
            "R1 reset state", {sram_ce_n, sram_we_n, sram_oe_n, sram_wdata_oe, req_ready}, 5'b11100);
        #1 rst_n = 1'b1;

        do_write(6'd0,  8'h00, 1);
        do_write(6'd63, 8'hFF, 0);
        do_write(6'd21, 8'hA5, 3);
        do_write(6'd42, 8'h5A, 0);

        // R1: reset in the middle of a pulse
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = 6'd5; req_data = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!sram_we_n, "R4 pulse under way before abort", sram_we_n, 0);
        #1 rst_n = 1'b0;
        @(negedge clk);
        chk(sram_ce_n && sram_we_n && !sram_wdata_oe && !req_ready,
            "R1 abort releases strobes", {sram_ce_n, sram_we_n, sram_wdata_oe, req_ready}, 4'b1100);
        @(negedge clk);
        #1 rst_n = 1'b1;
        do_write(6'd5, 8'h3C, 1);

        for (int i = 0; i < 40; i++) begin
            do_write(AW'($urandom % DEPTH), DW'($urandom), int'($urandom % 3));
        end
        repeat (E_WC + 2) @(negedge clk);

        for (int a = 0; a < DEPTH; a++) begin
            if (wrote[a])
                chk(mem[a] == model[a], "R9 stored word", mem[a], model[a]);
        end
        chk(sram_oe_n, "R8 output-enable high at end", sram_oe_n, 1);
        report();
        $finish;
    end

endmodule